// File: doc/BRIEF.md
# Gated Phase-Accumulator Rate Generator

This block produces a one-bit rate signal from a 48-bit phase accumulator. On every cycle in which the update-enable tick is high, a programmed increment is added to the phase register, and the top bit of that register is driven out through a flip-flop. The output frequency is therefore the tick rate times increment / 2^48. With a 16 MHz tick the finest step is about 57 nHz, and the fastest output is 8 MHz.

Software or a sequencer first loads a starting phase and an increment with a single load pulse. The generator then waits. It runs while an external start line is high, provided the stop line is also high. A falling edge on the stop line sends it back to waiting. Every new run reloads the starting phase, so every run produces exactly the same waveform. New values take effect only through another load. A load during a run cuts that run short.

Start and stop are asynchronous pins. Each passes through a two-flop synchroniser in the fast system clock domain, not the tick domain. A run therefore starts or halts on the third system clock edge after the pin changes.

Top module: `gated_rate_gen`

## Requirements
- R1: After reset, rate_out is low and the generator is unloaded: start_in and stop_in have no effect until the first cfg_load pulse.
- R2: A clock edge with cfg_load high captures cfg_phase and cfg_incr and puts the generator in the waiting state. While it waits with start_in low, rate_out stays low whatever upd_tick does.
- R3: In the waiting state, with stop_in high, a run begins on the third rising clock edge after start_in goes high. At that edge the accumulator takes the captured starting phase, and an upd_tick in that same cycle adds nothing.
- R4: While running, each clock edge with upd_tick high adds the captured increment to the accumulator modulo 2^48. Edges with upd_tick low leave the accumulator unchanged.
- R5: rate_out equals accumulator bit 47 while running and is low in every other state.
- R6: A high-to-low change on stop_in halts a run: rate_out is low from the third clock edge after the fall, and a tick in that cycle is discarded. start_in going low does not halt a run.
- R7: After a halt, a new run needs start_in high and stop_in high, so a low stop_in blocks a restart. Every run reloads the starting phase, so its output sequence repeats the previous run exactly.
- R8: Changes on cfg_phase and cfg_incr without cfg_load do nothing. A cfg_load during a run ends the run at that edge. The new values are used from the next run, which begins one edge later if start_in and stop_in are both high.
- R9: With cfg_incr = 2^47, rate_out toggles on every tick, giving an output at half the tick rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic and pin sampling run on it |
| rst | input | 1 | Synchronous active-high reset |
| upd_tick | input | 1 | Update enable; one accumulator step per high cycle while running |
| cfg_load | input | 1 | One-cycle pulse that captures the configuration and re-arms the generator |
| cfg_phase | input | 48 | Starting phase captured by cfg_load |
| cfg_incr | input | 48 | Per-tick increment captured by cfg_load |
| start_in | input | 1 | Asynchronous start line, active high |
| stop_in | input | 1 | Asynchronous stop line; a falling edge halts a run |
| rate_out | output | 1 | Registered top bit of the accumulator; low unless running |

## Verification
Two events can fall in the same cycle and are worth checking. An update tick can coincide with the cycle in which a run begins, and a tick can coincide with the cycle in which a stop fall is acted on. The bench provokes both by holding upd_tick high throughout, both while the start and stop lines pass through the synchronisers and during the halt. In the first case it chooses a starting phase one step below the bit-47 boundary. An output already high at the first running cycle would then show the tick had been wrongly added; the correct result is low, going high one edge later. In the second case the output must be low at the third edge after the stop fall, and the restart must replay the sequence from the unadvanced starting phase.

// File: rtl/rg_pkg.sv
package rg_pkg;

    localparam int unsigned RG_PHASE_W     = 48;
    localparam int unsigned RG_SYNC_STAGES = 2;
    localparam int unsigned RG_NUM_LINES   = 2;
    localparam int unsigned RG_LINE_START  = 0;
    localparam int unsigned RG_LINE_STOP   = 1;

    typedef enum logic [1:0] {
        RG_EMPTY = 2'd0,
        RG_ARMED = 2'd1,
        RG_RUN   = 2'd2
    } rg_state_e;

    typedef enum logic [1:0] {
        RG_ACC_HOLD = 2'd0,
        RG_ACC_LOAD = 2'd1,
        RG_ACC_STEP = 2'd2
    } rg_acc_cmd_e;

    typedef struct packed {
        logic start_lvl;
        logic stop_lvl;
    } rg_lines_t;

    function automatic logic rg_is_running(input rg_state_e s);
        return s == RG_RUN;
    endfunction

endpackage

// File: rtl/rg_sync.sv
module rg_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] lvl_o
);
    localparam int unsigned LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pins_i[g]};
            end
        end

        assign lvl_o[g] = chain_q[LAST];
    end

endmodule

// File: rtl/rg_cfg_regs.sv
module rg_cfg_regs #(
    parameter int unsigned W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] phase_i,
    input  logic [W-1:0] incr_i,
    output logic [W-1:0] phase_o,
    output logic [W-1:0] incr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= '0;
            incr_o  <= '0;
        end else if (load_i) begin
            phase_o <= phase_i;
            incr_o  <= incr_i;
        end
    end

endmodule

// File: rtl/rg_seq_ctrl.sv
module rg_seq_ctrl
    import rg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load_i,
    input  logic        tick_i,
    input  rg_lines_t   lines_i,
    output rg_state_e   state_o,
    output logic        run_nxt_o,
    output logic        halt_o,
    output rg_acc_cmd_e cmd_o
);
    rg_state_e state_q, state_d;
    logic      stop_prev_q;
    logic      go;

    assign halt_o = stop_prev_q & ~lines_i.stop_lvl;
    assign go     = lines_i.start_lvl & lines_i.stop_lvl;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RG_EMPTY: if (load_i) state_d = RG_ARMED;
            RG_ARMED: begin
                if (load_i)  state_d = RG_ARMED;
                else if (go) state_d = RG_RUN;
            end
            RG_RUN: begin
                if (load_i || halt_o) state_d = RG_ARMED;
            end
            default: state_d = RG_EMPTY;
        endcase
    end

    always_comb begin
        cmd_o = RG_ACC_HOLD;
        if (rg_is_running(state_d)) begin
            if (!rg_is_running(state_q)) cmd_o = RG_ACC_LOAD;
            else if (tick_i)             cmd_o = RG_ACC_STEP;
        end
    end

    assign run_nxt_o = rg_is_running(state_d);
    assign state_o   = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= RG_EMPTY;
            stop_prev_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            stop_prev_q <= lines_i.stop_lvl;
        end
    end

endmodule

// File: rtl/rg_phase_acc.sv
module rg_phase_acc
    import rg_pkg::*;
#(
    parameter int unsigned W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  rg_acc_cmd_e  cmd_i,
    input  logic         run_nxt_i,
    input  logic [W-1:0] phase_i,
    input  logic [W-1:0] incr_i,
    output logic [W-1:0] acc_o,
    output logic         out_o
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] acc_q, acc_d;

    always_comb begin
        unique case (cmd_i)
            RG_ACC_LOAD: acc_d = phase_i;
            RG_ACC_STEP: acc_d = acc_q + incr_i;
            default:     acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            out_o <= 1'b0;
        end else begin
            acc_q <= acc_d;
            out_o <= run_nxt_i ? acc_d[MSB] : 1'b0;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/gated_rate_gen.sv
module gated_rate_gen
    import rg_pkg::*;
#(
    parameter int unsigned PHASE_W     = RG_PHASE_W,
    parameter int unsigned SYNC_STAGES = RG_SYNC_STAGES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd_tick,
    input  logic               cfg_load,
    input  logic [PHASE_W-1:0] cfg_phase,
    input  logic [PHASE_W-1:0] cfg_incr,
    input  logic               start_in,
    input  logic               stop_in,
    output logic               rate_out
);
    logic [RG_NUM_LINES-1:0] pins, lvl;
    rg_lines_t               lines;
    rg_state_e               state_q;
    rg_acc_cmd_e             acc_cmd;
    logic                    run_nxt;
    logic                    halt_evt;
    logic [PHASE_W-1:0]      phase_q, incr_q, acc_q;

    assign pins[RG_LINE_START] = start_in;
    assign pins[RG_LINE_STOP]  = stop_in;
    assign lines.start_lvl     = lvl[RG_LINE_START];
    assign lines.stop_lvl      = lvl[RG_LINE_STOP];

    rg_sync #(
        .WIDTH (RG_NUM_LINES),
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst   (rst),
        .pins_i(pins),
        .lvl_o (lvl)
    );

    rg_cfg_regs #(.W(PHASE_W)) cfg_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (cfg_load),
        .phase_i(cfg_phase),
        .incr_i (cfg_incr),
        .phase_o(phase_q),
        .incr_o (incr_q)
    );

    rg_seq_ctrl ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .load_i   (cfg_load),
        .tick_i   (upd_tick),
        .lines_i  (lines),
        .state_o  (state_q),
        .run_nxt_o(run_nxt),
        .halt_o   (halt_evt),
        .cmd_o    (acc_cmd)
    );

    rg_phase_acc #(.W(PHASE_W)) acc_i (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (acc_cmd),
        .run_nxt_i(run_nxt),
        .phase_i  (phase_q),
        .incr_i   (incr_q),
        .acc_o    (acc_q),
        .out_o    (rate_out)
    );

endmodule

// File: rtl/rg_checker.sv
module rg_checker
    import rg_pkg::*;
#(
    parameter int unsigned W = 48
) (
    input logic         clk,
    input logic         rst,
    input rg_state_e    state_q,
    input logic [W-1:0] acc_q,
    input logic [W-1:0] phase_q,
    input logic [W-1:0] incr_q,
    input logic         upd_tick,
    input logic         halt_evt,
    input logic         cfg_load,
    input logic         rate_out
);
    p_empty_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == RG_EMPTY && !cfg_load) |=> (state_q == RG_EMPTY && !rate_out));

    p_out_low_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q != RG_RUN) |-> !rate_out);

    p_out_msb_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == RG_RUN) |-> (rate_out == acc_q[W-1]));

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == RG_RUN && upd_tick && !halt_evt && !cfg_load)
        |=> (acc_q == $past(acc_q) + $past(incr_q)));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == RG_RUN && !upd_tick && !halt_evt && !cfg_load) |=> $stable(acc_q));

    p_reload_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q != RG_RUN) ##1 (state_q == RG_RUN) |-> (acc_q == phase_q));

    p_halt_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == RG_RUN && halt_evt) |=> (state_q == RG_ARMED && !rate_out));

    p_load_abort_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (state_q == RG_ARMED));

    p_cfg_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> ($stable(phase_q) && $stable(incr_q)));

endmodule

bind gated_rate_gen rg_checker #(.W(PHASE_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .state_q (state_q),
    .acc_q   (acc_q),
    .phase_q (phase_q),
    .incr_q  (incr_q),
    .upd_tick(upd_tick),
    .halt_evt(halt_evt),
    .cfg_load(cfg_load),
    .rate_out(rate_out)
);

// File: tb/gated_rate_gen_tb_top.sv
`timescale 1ns/1ps
module gated_rate_gen_tb_top;
    localparam int W = 48;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         upd_tick = 1'b0;
    logic         cfg_load = 1'b0;
    logic [W-1:0] cfg_phase = '0;
    logic [W-1:0] cfg_incr = '0;
    logic         start_in = 1'b0;
    logic         stop_in = 1'b1;
    logic         rate_out;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gated_rate_gen dut_i (
        .clk(clk), .rst(rst), .upd_tick(upd_tick), .cfg_load(cfg_load),
        .cfg_phase(cfg_phase), .cfg_incr(cfg_incr),
        .start_in(start_in), .stop_in(stop_in), .rate_out(rate_out)
    );

    function automatic logic model_bit(input logic [W-1:0] p, input logic [W-1:0] i,
                                       input int unsigned k);
        logic [W-1:0] s;
        s = p + i * W'(k);
        return s[W-1];
    endfunction

    task automatic edge_step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rate_out=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; start_in = 1'b0; stop_in = 1'b1; upd_tick = 1'b1; cfg_load = 1'b0;
        repeat (3) edge_step();
        rst = 1'b0;
        edge_step();
    endtask

    task automatic do_load(input logic [W-1:0] p, input logic [W-1:0] i);
        cfg_phase = p; cfg_incr = i; cfg_load = 1'b1;
        edge_step();
        cfg_load = 1'b0;
    endtask

    task automatic go_run();
        start_in = 1'b1;
        repeat (3) edge_step();
    endtask

    task automatic run_cmp(input logic [W-1:0] p, input logic [W-1:0] i,
                           input int k0, input int n, input string tag);
        upd_tick = 1'b1;
        for (int k = k0; k < k0 + n; k++) begin
            check(rate_out, model_bit(p, i, k), tag);
            edge_step();
        end
    endtask

    task automatic t_reset_idle();
        do_reset();
        check(rate_out, 1'b0, "R1 reset value");
        start_in = 1'b1;
        for (int c = 0; c < 10; c++) begin
            edge_step();
            check(rate_out, 1'b0, "R1 start ignored before load");
        end
    endtask

    task automatic t_armed_hold();
        do_reset();
        do_load(48'h8000_0000_0000, 48'h1);
        for (int c = 0; c < 12; c++) begin
            upd_tick = c[0];
            edge_step();
            check(rate_out, 1'b0, "R2 waiting with start low");
        end
    endtask

    task automatic t_start_latency();
        do_reset();
        do_load(48'h8000_0000_0000, 48'h0);
        start_in = 1'b1;
        edge_step(); check(rate_out, 1'b0, "R3 edge 1 still waiting");
        edge_step(); check(rate_out, 1'b0, "R3 edge 2 still waiting");
        edge_step(); check(rate_out, 1'b1, "R3 edge 3 running");
    endtask

    task automatic t_accumulate();
        do_reset();
        do_load(48'h7FFF_FFFF_FFFD, 48'h1);
        go_run();
        run_cmp(48'h7FFF_FFFF_FFFD, 48'h1, 0, 6, "R4 carry into bit 47");
    endtask

    task automatic t_start_tick_same_cycle();
        do_reset();
        do_load(48'h7FFF_FFFF_FFFF, 48'h1);
        go_run();
        check(rate_out, 1'b0, "R3 tick at start edge not added");
        edge_step();
        check(rate_out, 1'b1, "R3 first tick after start");
    endtask

    task automatic t_tick_gaps();
        int cnt;
        do_reset();
        do_load(48'h0, 48'h4000_0000_0000);
        go_run();
        cnt = 0;
        for (int c = 0; c < 24; c++) begin
            upd_tick = (c % 3 == 0);
            edge_step();
            if (c % 3 == 0) cnt++;
            check(rate_out, model_bit(48'h0, 48'h4000_0000_0000, cnt), "R4 gated ticks");
        end
        upd_tick = 1'b1;
    endtask

    task automatic t_max_rate();
        do_reset();
        do_load(48'h0, 48'h8000_0000_0000);
        go_run();
        for (int k = 0; k < 8; k++) begin
            check(rate_out, k[0], "R9 toggle per tick");
            edge_step();
        end
    endtask

    task automatic t_stop_restart();
        logic [W-1:0] p, i;
        p = 48'h3000_0000_0000; i = 48'h2000_0000_0000;
        do_reset();
        do_load(p, i);
        go_run();
        run_cmp(p, i, 0, 10, "R5 first run");
        stop_in = 1'b0;
        repeat (3) edge_step();
        check(rate_out, 1'b0, "R6 halted at third edge after stop fall");
        for (int c = 0; c < 8; c++) begin
            edge_step();
            check(rate_out, 1'b0, "R7 stop low blocks restart");
        end
        stop_in = 1'b1;
        repeat (3) edge_step();
        run_cmp(p, i, 0, 10, "R7 second run repeats first");
    endtask

    task automatic t_start_drop();
        logic [W-1:0] p, i;
        p = 48'h0; i = 48'h2000_0000_0000;
        do_reset();
        do_load(p, i);
        go_run();
        run_cmp(p, i, 0, 4, "R6 before start drop");
        start_in = 1'b0;
        run_cmp(p, i, 4, 12, "R6 start low keeps running");
    endtask

    task automatic t_reload();
        logic [W-1:0] p, i;
        p = 48'h0; i = 48'h2000_0000_0000;
        do_reset();
        do_load(p, i);
        go_run();
        run_cmp(p, i, 0, 3, "R8 before changes");
        cfg_phase = 48'hFFFF_FFFF_FFFF; cfg_incr = 48'h0;
        run_cmp(p, i, 3, 8, "R8 inputs without load ignored");
        cfg_phase = 48'h8000_0000_0000; cfg_incr = 48'h0; cfg_load = 1'b1;
        edge_step();
        cfg_load = 1'b0;
        check(rate_out, 1'b0, "R8 load aborts run");
        edge_step();
        check(rate_out, 1'b1, "R8 new phase on next run");
        edge_step();
        check(rate_out, 1'b1, "R8 new zero increment holds");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run not finished (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        t_reset_idle();
        t_armed_hold();
        t_start_latency();
        t_accumulate();
        t_start_tick_same_cycle();
        t_tick_gaps();
        t_max_rate();
        t_stop_restart();
        t_start_drop();
        t_reload();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule